// File: doc/BRIEF.md
# Frame BIP Error Counter

This block measures the bit error rate of a received framed line from its bit-interleaved parity. Each covered byte of a frame is folded into one of three 8-bit parity lanes, taken in turn. The result is a 24-bit even parity word for the frame. The frame that follows carries the matching parity bytes. When the next frame marker arrives, the block compares the stored parity of the older frame with the bytes captured from the newer one. It counts the differing bits and adds that count to a 16-bit accumulator.

Software reads the total with a one-cycle read strobe. The read returns every error found since the previous read and clears the total in the same step. To get an error rate, divide the value read by the number of bits received between the two reads. Frame alignment, descrambling and the register bus sit outside this block. The block receives frame-start and byte-role markers as inputs.

Top module: `bip_err_counter`

## Requirements
- R1: While reset is held, and after its release until the first read, `rd_valid` is 0 and `rd_count` is 0. The first read after reset returns 0.
- R2: Covered bytes (`byte_vld` and `byte_cov` both high) are XOR-folded into lanes 0, 1, 2, 0, ... in arrival order. The lane order restarts at each frame start. Lane L occupies parity bits [8L+7:8L]. A received parity byte tagged with `bip_sel` = L fills the same bit range.
- R3: At each frame start, the computed parity of the frame two back is compared with the parity bytes received in the frame just ended. The first two frame starts after reset add nothing.
- R4: The count added per frame is the number of differing parity bits, from 0 to 24. A frame with matching parity adds nothing.
- R5: The count found at a frame start is added to the total on the clock edge after the one that sampled the frame start.
- R6: A one-cycle `rd_stb` causes `rd_valid` to be high for exactly the next cycle, with `rd_count` holding the total as it was before that edge. The total becomes zero, so a second read with no new errors returns 0.
- R7: If a read strobe and a pending frame count are sampled on the same edge, the read returns the old total. The pending count becomes the new total, so no error is lost.
- R8: The total saturates at 65535 instead of wrapping. After a read it counts up again from the new errors.
- R9: A parity byte with `bip_sel` = 3 is discarded. A valid byte with `byte_cov` low does not change the computed parity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_start | input | 1 | One-cycle marker opening a new frame |
| byte_vld | input | 1 | A received byte is present on `byte_in` |
| byte_in | input | 8 | Received byte |
| byte_cov | input | 1 | Byte is covered by the frame parity |
| byte_bip | input | 1 | Byte is a received parity byte |
| bip_sel | input | 2 | Parity lane of a received parity byte (0 to 2) |
| rd_stb | input | 1 | One-cycle read-and-clear request |
| rd_valid | output | 1 | `rd_count` carries a fresh read result |
| rd_count | output | 16 | Error total returned by the last read |

## Verification
The collision case has the per-frame error add and the clear-on-read fall on the same clock edge. The bench provokes it by raising the read strobe in the cycle right after a frame start whose parity comparison finds 24 errors. The read must return the total from before that frame, and a second read must return exactly the 24 that seeded the cleared total. A behavioural reference model, updated on every clock, checks that neither the old total nor the new count is dropped or counted twice.

// File: rtl/bip_ctr_pkg.sv
package bip_ctr_pkg;

  // number of set bits in a word of up to 64 bits
  function automatic int unsigned ones64(input logic [63:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < 64; i++) begin
      if (v[i]) n++;
    end
    return n;
  endfunction

  // width of an index able to address n items (at least 1 bit)
  function automatic int unsigned idx_bits(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/bip_lane_calc.sv
module bip_lane_calc #(
  parameter int LANES  = 3,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    frm_start,
  input  logic                    byte_vld,
  input  logic                    byte_cov,
  input  logic [LANE_W-1:0]       byte_in,
  output logic [LANES*LANE_W-1:0] prev_par
);
  localparam int BIP_W = LANES * LANE_W;
  localparam int LIX_W = bip_ctr_pkg::idx_bits(LANES);

  logic [BIP_W-1:0] run_par, run_nxt;
  logic [LIX_W-1:0] lane, lane_cur, lane_nxt;
  logic             hit;

  assign hit      = byte_vld && byte_cov;
  assign lane_cur = frm_start ? '0 : lane;

  // R2: each lane restarts at frame start and folds in its share of covered bytes
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign run_nxt[g*LANE_W +: LANE_W] =
      (frm_start ? '0 : run_par[g*LANE_W +: LANE_W]) ^
      ((hit && lane_cur == LIX_W'(g)) ? byte_in : '0);
  end

  always_comb begin
    lane_nxt = lane_cur;
    if (hit) lane_nxt = (lane_cur == LIX_W'(LANES-1)) ? '0 : lane_cur + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_par  <= '0;
      lane     <= '0;
      prev_par <= '0;
    end else begin
      run_par <= run_nxt;
      lane    <= lane_nxt;
      if (frm_start) prev_par <= run_par;
    end
  end

  // R2: a frame start with no covered byte leaves an all-zero running parity
  a_r2_restart: assert property (@(posedge clk) disable iff (!rst_n)
    frm_start && !hit |=> run_par == '0);

  // R9: uncovered bytes never change the running parity
  a_r9_uncovered: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_start && !hit |=> $stable(run_par));

endmodule

// File: rtl/bip_rx_capture.sv
module bip_rx_capture #(
  parameter int LANES  = 3,
  parameter int LANE_W = 8
) (
  input  logic                                       clk,
  input  logic                                       rst_n,
  input  logic                                       byte_vld,
  input  logic                                       byte_bip,
  input  logic [bip_ctr_pkg::idx_bits(LANES)-1:0]    bip_sel,
  input  logic [LANE_W-1:0]                          byte_in,
  output logic [LANES*LANE_W-1:0]                    rx_par
);
  localparam int LIX_W = bip_ctr_pkg::idx_bits(LANES);

  logic take;
  assign take = byte_vld && byte_bip;

  for (genvar g = 0; g < LANES; g++) begin : g_rx
    always_ff @(posedge clk) begin
      if (!rst_n) rx_par[g*LANE_W +: LANE_W] <= '0;
      else if (take && bip_sel == LIX_W'(g)) rx_par[g*LANE_W +: LANE_W] <= byte_in;
    end
  end

  // R9: a lane select beyond the last lane stores nothing
  a_r9_bad_sel: assert property (@(posedge clk) disable iff (!rst_n)
    take && (32'(bip_sel) >= 32'(LANES)) |=> $stable(rx_par));

endmodule

// File: rtl/bip_mismatch.sv
module bip_mismatch #(
  parameter int BIP_W = 24,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frm_start,
  input  logic [BIP_W-1:0] prev_par,
  input  logic [BIP_W-1:0] rx_par,
  output logic             err_v,
  output logic [CNT_W-1:0] err_cnt
);
  logic [1:0] starts;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      starts  <= '0;
      err_v   <= 1'b0;
      err_cnt <= '0;
    end else begin
      err_v <= 1'b0;
      if (frm_start) begin
        if (starts != 2'd2) starts <= starts + 2'd1;
        err_v   <= (starts == 2'd2);
        err_cnt <= CNT_W'(bip_ctr_pkg::ones64(64'(prev_par ^ rx_par)));
      end
    end
  end

  // R3: a count is only offered right after a frame start
  a_r3_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    err_v |-> $past(frm_start));

  // R4: never more errors than parity bits
  a_r4_bound: assert property (@(posedge clk) disable iff (!rst_n)
    err_v |-> 32'(err_cnt) <= 32'(BIP_W));

endmodule

// File: rtl/bip_accum.sv
module bip_accum #(
  parameter int ACC_W = 16,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             err_v,
  input  logic [CNT_W-1:0] err_cnt,
  input  logic             rd_stb,
  output logic             rd_valid,
  output logic [ACC_W-1:0] rd_count
);
  logic [ACC_W-1:0] acc, inc;

  function automatic logic [ACC_W-1:0] sat_add(input logic [ACC_W-1:0] a,
                                               input logic [ACC_W-1:0] b);
    logic [ACC_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[ACC_W] ? '1 : s[ACC_W-1:0];
  endfunction

  assign inc = err_v ? ACC_W'(err_cnt) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc      <= '0;
      rd_valid <= 1'b0;
      rd_count <= '0;
    end else begin
      rd_valid <= rd_stb;
      if (rd_stb) begin
        rd_count <= acc;
        acc      <= inc;
      end else begin
        acc <= sat_add(acc, inc);
      end
    end
  end

  // R6: read returns the pre-edge total and pulses valid
  a_r6_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> rd_valid && rd_count == $past(acc));

  // R6: a plain read empties the total
  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb && !err_v |=> acc == '0);

  // R7: a colliding count seeds the cleared total
  a_r7_seed: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb && err_v |=> acc == ACC_W'($past(err_cnt)));

  // R8: without a read the total never decreases
  a_r8_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> acc >= $past(acc));

endmodule

// File: rtl/bip_err_counter.sv
module bip_err_counter #(
  parameter int LANES  = 3,
  parameter int LANE_W = 8,
  parameter int ACC_W  = 16
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    frm_start,
  input  logic                                    byte_vld,
  input  logic [LANE_W-1:0]                       byte_in,
  input  logic                                    byte_cov,
  input  logic                                    byte_bip,
  input  logic [bip_ctr_pkg::idx_bits(LANES)-1:0] bip_sel,
  input  logic                                    rd_stb,
  output logic                                    rd_valid,
  output logic [ACC_W-1:0]                        rd_count
);
  localparam int BIP_W = LANES * LANE_W;
  localparam int CNT_W = $clog2(BIP_W + 1);

  logic [BIP_W-1:0] prev_par, rx_par;
  logic             err_v;
  logic [CNT_W-1:0] err_cnt;

  bip_lane_calc #(.LANES(LANES), .LANE_W(LANE_W)) u_calc (
    .clk(clk), .rst_n(rst_n), .frm_start(frm_start), .byte_vld(byte_vld),
    .byte_cov(byte_cov), .byte_in(byte_in), .prev_par(prev_par));

  bip_rx_capture #(.LANES(LANES), .LANE_W(LANE_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_bip(byte_bip),
    .bip_sel(bip_sel), .byte_in(byte_in), .rx_par(rx_par));

  bip_mismatch #(.BIP_W(BIP_W), .CNT_W(CNT_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .frm_start(frm_start), .prev_par(prev_par),
    .rx_par(rx_par), .err_v(err_v), .err_cnt(err_cnt));

  bip_accum #(.ACC_W(ACC_W), .CNT_W(CNT_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .err_v(err_v), .err_cnt(err_cnt),
    .rd_stb(rd_stb), .rd_valid(rd_valid), .rd_count(rd_count));

  // R5: a frame count reaches the total one edge after the frame start
  a_r5_add_latency: assert property (@(posedge clk) disable iff (!rst_n)
    err_v |-> $past(frm_start));

endmodule

// File: tb/test_bip_err_counter.sv
module test_bip_err_counter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frm_start = 1'b0, byte_vld = 1'b0, byte_cov = 1'b0, byte_bip = 1'b0, rd_stb = 1'b0;
  logic [7:0]  byte_in = '0;
  logic [1:0]  bip_sel = '0;
  logic        rd_valid;
  logic [15:0] rd_count;

  int checks = 0, errors = 0;
  bit done = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;  // 125 MHz

  bip_err_counter i_bip_err_counter (
    .clk(clk), .rst_n(rst_n), .frm_start(frm_start), .byte_vld(byte_vld),
    .byte_in(byte_in), .byte_cov(byte_cov), .byte_bip(byte_bip),
    .bip_sel(bip_sel), .rd_stb(rd_stb), .rd_valid(rd_valid), .rd_count(rd_count));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int pop24(input logic [23:0] v);
    int n = 0;
    for (int i = 0; i < 24; i++) if (v[i]) n++;
    return n;
  endfunction

  function automatic logic [7:0] pay(input int seed, input int i);
    return 8'((seed * 13 + i * 37 + 1) & 255);
  endfunction

  // expected parity: byte i lands in lane i mod 3
  function automatic logic [23:0] exp_par(input int npay, input int seed);
    logic [7:0] ln [3];
    for (int k = 0; k < 3; k++) ln[k] = 8'h00;
    for (int i = 0; i < npay; i++) ln[i % 3] ^= pay(seed, i);
    return {ln[2], ln[1], ln[0]};
  endfunction

  // behavioural reference, updated on every rising edge
  logic [7:0] m_run [3];
  logic [7:0] m_prev [3];
  logic [7:0] m_rx [3];
  int m_lane, m_starts, m_errc, m_acc, m_rdd;
  bit m_errv, m_rdv;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 3; k++) begin m_run[k] = 0; m_prev[k] = 0; m_rx[k] = 0; end
      m_lane = 0; m_starts = 0; m_errc = 0; m_acc = 0; m_rdd = 0; m_errv = 0; m_rdv = 0;
    end else begin
      int add;
      bit nv;
      int nc;
      add = m_errv ? m_errc : 0;
      if (rd_stb) begin
        m_rdd = m_acc; m_rdv = 1; m_acc = add;
      end else begin
        m_rdv = 0;
        m_acc = (m_acc + add > 65535) ? 65535 : m_acc + add;
      end
      nv = 0; nc = m_errc;
      if (frm_start) begin
        nv = (m_starts >= 2);
        nc = pop24({m_prev[2], m_prev[1], m_prev[0]} ^ {m_rx[2], m_rx[1], m_rx[0]});
        for (int k = 0; k < 3; k++) begin m_prev[k] = m_run[k]; m_run[k] = 0; end
        m_lane = 0;
        if (m_starts < 2) m_starts++;
      end
      m_errv = nv; m_errc = nc;
      if (byte_vld && byte_cov) begin
        m_run[m_lane] ^= byte_in;
        m_lane = (m_lane + 1) % 3;
      end
      if (byte_vld && byte_bip && bip_sel < 3) m_rx[bip_sel] = byte_in;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done)
      check(rd_valid == m_rdv && int'(rd_count) == m_rdd, cur_req,
            int'(rd_count) + (rd_valid ? 100000 : 0), m_rdd + (m_rdv ? 100000 : 0));
  end

  task automatic frame(input int npay, input int seed, input logic [23:0] rx,
                       input bit junk, input bit coll, input int coll_exp);
    frm_start = 1; @(negedge clk); frm_start = 0;
    if (coll) begin
      rd_stb = 1; @(negedge clk); rd_stb = 0;
      check(rd_valid && int'(rd_count) == coll_exp, "R7", int'(rd_count), coll_exp);
    end
    for (int i = 0; i < npay; i++) begin
      byte_vld = 1; byte_cov = 1; byte_in = pay(seed, i); @(negedge clk);
    end
    byte_cov = 0;
    if (junk) begin
      byte_vld = 1; byte_bip = 1; bip_sel = 2'd3; byte_in = 8'hA5; @(negedge clk);
      byte_bip = 0; byte_in = 8'h3C; @(negedge clk);
    end
    for (int l = 0; l < 3; l++) begin
      byte_vld = 1; byte_bip = 1; bip_sel = 2'(l); byte_in = rx[l*8 +: 8]; @(negedge clk);
    end
    byte_vld = 0; byte_bip = 0; bip_sel = 0; byte_in = 0;
  endtask

  task automatic read(input int exp, input string req);
    rd_stb = 1; @(negedge clk); rd_stb = 0;
    check(rd_valid && int'(rd_count) == exp, req, int'(rd_count), exp);
    @(negedge clk);
    check(!rd_valid, req, int'(rd_valid), 0);
  endtask

  // a frame with payload, a frame carrying its parity xor flip, then a filler that triggers the compare
  task automatic trio(input int npay, input int seed, input logic [23:0] flip, input bit junk);
    frame(npay, seed, 24'h0, junk, 0, 0);
    frame(0, 0, exp_par(npay, seed) ^ flip, 0, 0, 0);
    frame(0, 0, 24'h0, 0, 0, 0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(rd_valid == 0 && rd_count == 0, "R1 reset", int'(rd_count), 0);
    rst_n = 1; @(negedge clk);
    check(rd_valid == 0 && rd_count == 0, "R1 idle", int'(rd_count), 0);
    read(0, "R1 first read");

    cur_req = "R3";
    frame(0, 0, 24'hFFFFFF, 0, 0, 0);
    frame(0, 0, 24'hFFFFFF, 0, 0, 0);
    read(0, "R3 warmup adds nothing");
    frame(0, 0, 24'h0, 0, 0, 0);
    repeat (2) @(negedge clk);
    read(24, "R3 third start compares");

    cur_req = "R2";
    trio(9, 5, 24'h0, 0);
    read(0, "R2 matching parity");
    cur_req = "R4";
    trio(6, 11, 24'h010204, 0);
    read(3, "R4 three bits");
    trio(7, 2, 24'hFFFFFF, 0);
    read(24, "R4 all bits");
    trio(1, 7, 24'h800000, 0);
    read(1, "R5 single bit");

    cur_req = "R9";
    trio(5, 3, 24'h0, 1);
    read(0, "R9 junk ignored");

    cur_req = "R7";
    trio(0, 0, 24'hFFFFFF, 0);
    frame(0, 0, 24'h0, 0, 0, 0);
    frame(0, 0, 24'hFFFFFF, 0, 0, 0);
    frame(0, 0, 24'h0, 0, 1, 24);
    read(24, "R7 seed kept");
    read(0, "R6 cleared");

    cur_req = "R8";
    for (int n = 0; n < 2800; n++) frame(0, 0, 24'hFFFFFF, 0, 0, 0);
    frame(0, 0, 24'h0, 0, 0, 0);
    read(65535, "R8 saturated");
    frame(0, 0, 24'h0, 0, 0, 0);
    read(0, "R8 after clear");
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual 1 expected 0");
    finish_run();
  end
endmodule